// File: doc/BRIEF.md
# Bit-Serial Handshake Link Master

This block is the host end of a two-wire link to a peripheral controller. One wire is a shared data line that either end can pull low and that reads high only when both ends let go of it. The other carries the peripheral's per-bit acknowledge back to the host. The host writes a four-bit link register for each bit. For every bit it waits until the peripheral pulls the acknowledge low, and then until the acknowledge is released again. There is no bit clock.

A request asks for a transfer of 1 to 16 bits in one of two directions. To send, the block shifts the request word out, most significant bit first. To receive, it releases the data line for every bit, because a low pulled by the host would hide the peripheral's value. It then shifts in the level it samples at the acknowledge. Each transfer ends with a single-cycle response that carries the received word or an error flag. A transfer that stalls past a programmable number of cycles is aborted.

Top module: `lnk_master`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy` and `rsp_valid` are 0, `req_ready` is 1, `link_wr_stb` is 0 and `link_wr` is 4'b1110.
- R2: A request is taken when `req_valid` and `req_ready` are both high. `busy` is then 1 and `req_ready` is 0 from the next cycle until the transfer ends. Requests presented while busy are not taken.
- R3: `req_len_m1` holds the bit count minus one, so 0 means 1 bit and 15 means 16 bits. For a send (`req_dir`=0), each bit is written as `link_wr`={1,1,b,0} with `b` in bit 1, together with a one-cycle `link_wr_stb`. The lowest `req_len_m1`+1 bits of `req_data` go out most significant first.
- R4: For a receive (`req_dir`=1), each bit is written as `link_wr`=4'b1110 with a strobe, and `link_rd_bit` is sampled in the cycle the acknowledge is seen low. The first bit sampled is the most significant. The result is right-aligned in `rsp_data`, and the bits above it are zero.
- R5: The next bit is written only after the acknowledge `link_ack_n` has gone low for the current bit and has then been seen high again. A strobe never follows a cycle in which `link_ack_n` was low.
- R6: A successful transfer produces `rsp_valid` for exactly one cycle with `rsp_err`=0. A send returns `rsp_data`=0. `busy` is already 0 in the response cycle.
- R7: If `cfg_timeout`=L is nonzero and the block waits L cycles in a row for the same acknowledge edge without seeing it, the transfer aborts. The abort gives a one-cycle `rsp_valid` with `rsp_err`=1 and `rsp_data`=0.
- R8: An acknowledge seen in the last allowed waiting cycle completes the bit normally. It takes precedence over the timeout.
- R9: When `cfg_timeout`=0, no timeout occurs and the block keeps waiting.
- R10: Whenever the block is not busy, including after an abort, `link_wr` is 4'b1110 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_dir | input | 1 | 0 = send, 1 = receive |
| req_len_m1 | input | 4 | Bit count minus one |
| req_data | input | 16 | Word to send, right-aligned |
| cfg_timeout | input | 16 | Waiting-cycle limit per acknowledge edge; 0 disables it |
| busy | output | 1 | Transfer in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is a timeout abort |
| rsp_data | output | 16 | Received word, right-aligned |
| link_wr | output | 4 | Link write register value {1,1,data,0} |
| link_wr_stb | output | 1 | One-cycle pulse when the link register is written for a bit |
| link_ack_n | input | 1 | Peripheral acknowledge, low when the bit is taken or supplied |
| link_rd_bit | input | 1 | Level of the wired-AND data line |

## Verification
Two functions can fall in the same cycle: the final acknowledge and the expiry of the timeout counter. The bench sets the limit to 10 and tells its peripheral model how long to wait before acknowledging. One case lands the acknowledge exactly in the last allowed waiting cycle, and the response must carry `rsp_err`=0. A second case delays the acknowledge by one more cycle, and the response must be an error. These two results bracket the precedence rule from both sides.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    parameter int unsigned LNK_MAX_BITS = 16;
    localparam int unsigned LNK_LEN_W = $clog2(LNK_MAX_BITS);

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_HI = 2'd1,
        ST_WAIT_LO = 2'd2
    } lnk_state_e;

    typedef enum logic {
        DIR_SEND = 1'b0,
        DIR_RECV = 1'b1
    } lnk_dir_e;

    typedef struct packed {
        logic                    err;
        logic [LNK_MAX_BITS-1:0] data;
    } lnk_rsp_t;

    localparam logic [3:0] WR_RELEASED = 4'b1110;

    function automatic logic [3:0] wr_frame(input logic b);
        return {2'b11, b, 1'b0};
    endfunction

endpackage

// File: rtl/lnk_shift.sv
module lnk_shift #(
    parameter int unsigned W  = 16,
    parameter int unsigned LW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          load_recv,
    input  logic [LW-1:0] load_len_m1,
    input  logic [W-1:0]  load_data,
    input  logic          step,
    input  logic          step_in,
    output logic          head_bit,
    output logic          last_bit,
    output logic [W-1:0]  word
);
    localparam logic [LW:0] TOP_IDX = (LW+1)'(W - 1);

    logic [W-1:0]  sh_q;
    logic [LW-1:0] left_q;
    logic [LW:0]   align;

    assign align = TOP_IDX - {1'b0, load_len_m1};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sh_q   <= load_recv ? '0 : (load_data << align);
            left_q <= load_len_m1;
        end else if (step) begin
            sh_q   <= {sh_q[W-2:0], step_in};
            left_q <= left_q - 1'b1;
        end
    end

    assign head_bit = sh_q[W-1];
    assign last_bit = (left_q == '0);
    assign word     = sh_q;
endmodule

// File: rtl/lnk_tmo.sv
module lnk_tmo #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && (limit != '0) && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/lnk_master.sv
module lnk_master
    import lnk_pkg::*;
#(
    parameter int unsigned TMO_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_dir,
    input  logic [LNK_LEN_W-1:0]    req_len_m1,
    input  logic [LNK_MAX_BITS-1:0] req_data,
    input  logic [TMO_W-1:0]        cfg_timeout,
    output logic                    busy,
    output logic                    rsp_valid,
    output logic                    rsp_err,
    output logic [LNK_MAX_BITS-1:0] rsp_data,
    output logic [3:0]              link_wr,
    output logic                    link_wr_stb,
    input  logic                    link_ack_n,
    input  logic                    link_rd_bit
);
    localparam int unsigned DW = LNK_MAX_BITS;
    localparam int unsigned LW = LNK_LEN_W;

    lnk_state_e     state_q;
    lnk_dir_e       dir_q;
    lnk_rsp_t       rsp_q;
    logic           rsp_v_q;
    logic [3:0]     wr_q;
    logic           stb_q;

    logic           accept;
    logic           waiting;
    logic           progress;
    logic           step;
    logic           expire;
    logic           head_bit;
    logic           last_bit;
    logic [DW-1:0]  word;
    logic [DW-1:0]  word_next;

    assign accept  = req_valid && (state_q == ST_IDLE);
    assign waiting = (state_q == ST_WAIT_HI) || (state_q == ST_WAIT_LO);
    assign step    = (state_q == ST_WAIT_LO) && !link_ack_n;

    always_comb begin
        case (state_q)
            ST_WAIT_HI: progress = link_ack_n;
            ST_WAIT_LO: progress = !link_ack_n;
            default:    progress = 1'b0;
        endcase
    end

    assign word_next = {word[DW-2:0], (dir_q == DIR_RECV) ? link_rd_bit : 1'b0};

    lnk_shift #(.W(DW), .LW(LW)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .load        (accept),
        .load_recv   (req_dir),
        .load_len_m1 (req_len_m1),
        .load_data   (req_data),
        .step        (step),
        .step_in     ((dir_q == DIR_RECV) ? link_rd_bit : 1'b0),
        .head_bit    (head_bit),
        .last_bit    (last_bit),
        .word        (word)
    );

    lnk_tmo #(.TW(TMO_W)) u_tmo (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept || progress),
        .run    (waiting),
        .limit  (cfg_timeout),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dir_q   <= DIR_SEND;
            rsp_q   <= '0;
            rsp_v_q <= 1'b0;
            wr_q    <= WR_RELEASED;
            stb_q   <= 1'b0;
        end else begin
            stb_q     <= 1'b0;
            rsp_v_q   <= 1'b0;
            rsp_q.err <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_WAIT_HI;
                        dir_q   <= lnk_dir_e'(req_dir);
                    end
                end
                ST_WAIT_HI: begin
                    if (link_ack_n) begin
                        wr_q    <= (dir_q == DIR_RECV) ? WR_RELEASED : wr_frame(head_bit);
                        stb_q   <= 1'b1;
                        state_q <= ST_WAIT_LO;
                    end else if (expire) begin
                        state_q    <= ST_IDLE;
                        wr_q       <= WR_RELEASED;
                        rsp_v_q    <= 1'b1;
                        rsp_q.err  <= 1'b1;
                        rsp_q.data <= '0;
                    end
                end
                ST_WAIT_LO: begin
                    if (!link_ack_n) begin
                        if (last_bit) begin
                            state_q    <= ST_IDLE;
                            wr_q       <= WR_RELEASED;
                            rsp_v_q    <= 1'b1;
                            rsp_q.data <= (dir_q == DIR_RECV) ? word_next : '0;
                        end else begin
                            state_q <= ST_WAIT_HI;
                        end
                    end else if (expire) begin
                        state_q    <= ST_IDLE;
                        wr_q       <= WR_RELEASED;
                        rsp_v_q    <= 1'b1;
                        rsp_q.err  <= 1'b1;
                        rsp_q.data <= '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign busy        = (state_q != ST_IDLE);
    assign rsp_valid   = rsp_v_q;
    assign rsp_err     = rsp_q.err;
    assign rsp_data    = rsp_q.data;
    assign link_wr     = wr_q;
    assign link_wr_stb = stb_q;
endmodule

// File: rtl/lnk_master_chk.sv
module lnk_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        busy,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [15:0] rsp_data,
    input logic [3:0]  link_wr,
    input logic        link_wr_stb,
    input logic        link_ack_n
);
    a_r2_busy_after_take: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy);

    a_r6_rsp_single: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r6_idle_at_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !busy);

    a_r5_stb_after_release: assert property (@(posedge clk) disable iff (rst)
        link_wr_stb |-> $past(link_ack_n));

    a_r3_frame_shape: assert property (@(posedge clk) disable iff (rst)
        link_wr_stb |-> (link_wr[3:2] == 2'b11 && !link_wr[0]));

    a_r10_idle_released: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (link_wr == 4'b1110));

    a_r7_err_shape: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_data == '0));
endmodule

bind lnk_master lnk_master_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .busy        (busy),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_data    (rsp_data),
    .link_wr     (link_wr),
    .link_wr_stb (link_wr_stb),
    .link_ack_n  (link_ack_n)
);

// File: tb/sim_lnk_master.sv
module sim_lnk_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_dir = 1'b0;
    logic [3:0]  req_len_m1 = '0;
    logic [15:0] req_data = '0;
    logic [15:0] cfg_timeout = '0;
    logic        busy, rsp_valid, rsp_err;
    logic [15:0] rsp_data;
    logic [3:0]  link_wr;
    logic        link_wr_stb;
    logic        link_ack_n;
    logic        link_rd_bit;

    always #5 clk = ~clk;

    lnk_master u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_dir(req_dir), .req_len_m1(req_len_m1), .req_data(req_data),
        .cfg_timeout(cfg_timeout), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_data(rsp_data), .link_wr(link_wr),
        .link_wr_stb(link_wr_stb), .link_ack_n(link_ack_n), .link_rd_bit(link_rd_bit)
    );

    // peripheral model settings
    int          pm_delay = 0;
    int          pm_hold  = 0;
    bit          pm_silent = 1'b0;
    logic [15:0] pm_tx = '0;
    int          pm_len = 1;

    logic        pa_n, p_pend, p_out;
    int          p_cnt, p_hold, p_idx, p_stb, p_bad;
    logic [15:0] p_rx;

    assign link_ack_n  = pa_n;
    assign link_rd_bit = link_wr[1] & p_out;

    always @(posedge clk) begin
        if (rst) begin
            pa_n <= 1'b1; p_pend <= 1'b0; p_out <= 1'b1;
            p_cnt <= 0; p_hold <= 0; p_idx <= 0; p_stb <= 0; p_bad <= 0; p_rx <= '0;
        end else begin
            if (req_valid && req_ready) begin
                p_idx <= 0; p_rx <= '0; p_stb <= 0;
            end
            if (link_wr_stb) begin
                p_stb <= p_stb + 1;
                if (!pa_n) p_bad <= p_bad + 1;
            end
            if (link_wr_stb && !pm_silent) begin
                p_pend <= 1'b1; p_cnt <= pm_delay;
            end else if (p_pend) begin
                if (p_cnt == 0) begin
                    pa_n   <= 1'b0;
                    p_hold <= pm_hold;
                    p_pend <= 1'b0;
                    p_rx   <= {p_rx[14:0], link_wr[1]};
                    p_out  <= pm_tx[pm_len-1-p_idx];
                    p_idx  <= p_idx + 1;
                end else begin
                    p_cnt <= p_cnt - 1;
                end
            end else if (!pa_n) begin
                if (p_hold == 0) begin
                    pa_n <= 1'b1; p_out <= 1'b1;
                end else begin
                    p_hold <= p_hold - 1;
                end
            end
        end
    end

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic        dir;
        logic [3:0]  len_m1;
        logic [15:0] data;
        logic [3:0]  dly;
        logic [3:0]  hld;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd7,  16'h00A5, 4'd0, 4'd0},
        '{1'b0, 4'd7,  16'h003C, 4'd3, 4'd1},
        '{1'b1, 4'd3,  16'h0009, 4'd1, 4'd4},
        '{1'b0, 4'd15, 16'hBEEF, 4'd0, 4'd2},
        '{1'b1, 4'd15, 16'h1234, 4'd2, 4'd0},
        '{1'b0, 4'd0,  16'h0001, 4'd5, 4'd5},
        '{1'b1, 4'd0,  16'h0001, 4'd0, 4'd3},
        '{1'b0, 4'd4,  16'hFFEA, 4'd2, 4'd0}
    };

    logic [15:0] got_data;
    bit          got_err;
    bit          got;

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic issue(input logic d, input logic [3:0] l, input logic [15:0] w);
        @(negedge clk);
        req_valid = 1'b1; req_dir = d; req_len_m1 = l; req_data = w;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp(input int limit);
        got = 1'b0;
        for (int i = 0; i < limit && !got; i++) begin
            if (rsp_valid) begin
                got = 1'b1; got_data = rsp_data; got_err = rsp_err;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk(!busy && req_ready && !rsp_valid && !link_wr_stb, "R1 idle flags",
            {busy, req_ready, rsp_valid, link_wr_stb}, 4'b0100);
        chk(link_wr == 4'b1110, "R1 link released", link_wr, 4'b1110);

        cfg_timeout = 16'd200;
        for (int v = 0; v < NV; v++) begin
            logic [15:0] mask;
            mask = 16'hFFFF >> (15 - VEC[v].len_m1);
            pm_delay = VEC[v].dly; pm_hold = VEC[v].hld; pm_silent = 1'b0;
            pm_tx = VEC[v].data; pm_len = VEC[v].len_m1 + 1;
            issue(VEC[v].dir, VEC[v].len_m1, VEC[v].data);
            chk(busy && !req_ready, "R2 busy after take", {busy, req_ready}, 2'b10);
            wait_rsp(3000);
            chk(got && !got_err, "R6 clean response", {got, got_err}, 2'b10);
            if (VEC[v].dir) begin
                chk(got_data == (VEC[v].data & mask), "R4 received word", got_data, VEC[v].data & mask);
            end else begin
                chk(got_data == 16'h0, "R6 send returns zero", got_data, 16'h0);
                chk(p_rx == (VEC[v].data & mask), "R3 bits sent msb first", p_rx, VEC[v].data & mask);
            end
            chk(p_stb == pm_len, "R3 strobe count", p_stb, pm_len);
            @(negedge clk);
            chk(!rsp_valid, "R6 valid one cycle", rsp_valid, 0);
            chk(link_wr == 4'b1110, "R10 released after transfer", link_wr, 4'b1110);
        end
        chk(p_bad == 0, "R5 no strobe while ack low", p_bad, 0);

        // R2: requests held while busy are not taken
        pm_delay = 6; pm_hold = 0; pm_tx = 16'h0002; pm_len = 2;
        issue(1'b1, 4'd1, 16'h0);
        @(negedge clk);
        req_valid = 1'b1; req_dir = 1'b0; req_len_m1 = 4'd15; req_data = 16'hFFFF;
        chk(!req_ready, "R2 not ready while busy", req_ready, 0);
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        wait_rsp(500);
        chk(got && got_data == 16'h0002, "R2 first transfer intact", got_data, 16'h0002);
        chk(p_stb == 2, "R2 no second transfer", p_stb, 2);

        // R8: acknowledge in the last allowed cycle wins
        do_reset();
        cfg_timeout = 16'd10; pm_delay = 7; pm_hold = 0; pm_silent = 1'b0; pm_len = 1; pm_tx = 16'h1;
        issue(1'b1, 4'd0, 16'h0);
        wait_rsp(200);
        chk(got && !got_err && got_data == 16'h1, "R8 ack beats timeout", {got_err, got_data}, 17'h1);

        // R7: one cycle later the timeout fires
        do_reset();
        cfg_timeout = 16'd10; pm_delay = 8;
        issue(1'b1, 4'd0, 16'h0);
        wait_rsp(200);
        chk(got && got_err && got_data == 16'h0, "R7 timeout abort", {got, got_err}, 2'b11);
        @(negedge clk);
        chk(!busy && link_wr == 4'b1110, "R10 released after abort", link_wr, 4'b1110);

        // R9: zero limit never times out
        do_reset();
        cfg_timeout = 16'd0; pm_silent = 1'b1;
        issue(1'b0, 4'd3, 16'h5);
        wait_rsp(400);
        chk(!got && busy, "R9 still waiting", {got, busy}, 2'b01);
        pm_silent = 1'b0;
        do_reset();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule